// File: doc/BRIEF.md
# Trigger-slaved timer counter

A general-purpose up/down counter whose clocking and control are chosen by a 3-bit slave-mode field. The counter can run from the system clock, step on strobes from an external quadrature decoder, or be controlled by one of several trigger lines. The selected trigger can reload the count, gate it by level, start it once, or act as the count clock itself. Trigger lines are synchronised and edge-detected inside the block.

Counting up, the value climbs from 0 and wraps back to 0 after reaching the preset. Counting down, it falls and reloads the preset after reaching 0. Each wrap produces a one-cycle update pulse. The preset can be double-buffered so that a new value only applies from the next wrap. Software programs the block through a simple write strobe with a combinational read-back.

Top module: `trig_slave_counter`

## Requirements
- R1: After reset, the count, the update pulse and all control fields read back as 0.
- R2: In slave mode 0 with enable set (control bit 0), the count changes by one on every clock. With enable clear, the count holds.
- R3: Counting up (control bit 4 = 0), a step taken from a count at or above the preset wraps the count to 0. `upd_o` is high for exactly the cycle in which the wrapped value appears.
- R4: Counting down (control bit 4 = 1), a step taken from 0 loads the preset with an `upd_o` pulse. Every other step decrements the count.
- R5: With control bit 7 set, a preset written at offset 0x2C is held in a shadow register and is used only after the next wrap. With bit 7 clear, it is used from the next clock. Offset 0x2C always reads back the written value.
- R6: In slave modes 1, 2 and 3, the count steps only on cycles with `enc_step_i` high, in the direction given by `enc_dir_i`. Control bit 4 follows `enc_dir_i`, and software writes to it have no effect.
- R7: In slave mode 4, a rising edge on the selected trigger reloads the preset into the count. The reload lands on the third clock edge after the input rises, and a trigger held high reloads only once.
- R8: In slave mode 5, the count steps only while the synchronised selected trigger is high. When the trigger falls, the count keeps its value.
- R9: In slave mode 6, a rising edge on the selected trigger sets the enable bit on the third clock edge, and counting continues from the held value without clearing.
- R10: In slave mode 7, the count takes exactly one step per rising edge of the selected trigger.
- R11: The trigger select is the field at bits 5:4 of offset 0x08, and the slave mode is at bits 2:0. Only the selected trigger line has any effect.
- R12: The control register at offset 0x00 stores only bits 0, 4 and 7. The live count reads at 0x24. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | N_TRIG | Asynchronous trigger source lines |
| enc_step_i | input | 1 | Step strobe from the encoder decoder |
| enc_dir_i | input | 1 | Direction from the encoder decoder, 1 = down |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| upd_o | output | 1 | One-cycle update pulse on wrap |

## Verification
- **Register writes:** a write takes effect on the rising edge that ends its strobe cycle. With enable set in mode 0, that same edge is already a counting step.
- **Trigger effects:** each trigger input change needs two edges to pass through the synchroniser, so its effect on the count lands on the third edge after the change.
- **Gated mode:** a falling trigger still lets two more steps through before the count holds.
- **Sampling:** the bench drives every stimulus on a falling edge and counts falling edges to the exact result edge. Read-back is sampled 1 ns after a falling edge, so each check lands one half-cycle after the edge that produced its expected value.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    SM_INTCLK = 3'd0,
    SM_ENC_A  = 3'd1,
    SM_ENC_B  = 3'd2,
    SM_ENC_AB = 3'd3,
    SM_RELOAD = 3'd4,
    SM_GATE   = 3'd5,
    SM_START  = 3'd6,
    SM_EXTCLK = 3'd7
  } smode_e;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SLAVE  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_PRESET = 8'h2C;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_DIR_BIT = 4;
  localparam int CTRL_PRE_BIT = 7;
  localparam int SLV_MODE_LSB = 0;
  localparam int SLV_TSEL_LSB = 4;

  function automatic logic is_enc(smode_e m);
    return (m == SM_ENC_A) || (m == SM_ENC_B) || (m == SM_ENC_AB);
  endfunction
endpackage

// File: rtl/tsc_trig_sync.sv
module tsc_trig_sync #(
  parameter int N_TRIG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  output logic [N_TRIG-1:0] lvl_o,
  output logic [N_TRIG-1:0] rise_o
);
  for (genvar g = 0; g < N_TRIG; g++) begin : g_line
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], trig_i[g]};
    end
    assign lvl_o[g]  = sh_q[1];
    assign rise_o[g] = sh_q[1] & ~sh_q[2];
  end
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int TSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_set_i,
  input  logic              enc_dir_i,
  output logic              en_o,
  output logic              dir_o,
  output logic              pre_en_o,
  output smode_e            mode_o,
  output logic [TSEL_W-1:0] tsel_o,
  output logic [CNT_W-1:0]  shadow_o
);
  logic wr_ctrl, wr_slave, wr_preset;
  logic unused_wdata;

  assign wr_ctrl   = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_slave  = wr_en_i && (addr_i == OFS_SLAVE);
  assign wr_preset = wr_en_i && (addr_i == OFS_PRESET);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      dir_o    <= 1'b0;
      pre_en_o <= 1'b0;
      mode_o   <= SM_INTCLK;
      tsel_o   <= '0;
      shadow_o <= '0;
    end else begin
      if (start_set_i)  en_o <= 1'b1;
      else if (wr_ctrl) en_o <= wdata_i[CTRL_EN_BIT];
      if (is_enc(mode_o)) dir_o <= enc_dir_i;
      else if (wr_ctrl)   dir_o <= wdata_i[CTRL_DIR_BIT];
      if (wr_ctrl) pre_en_o <= wdata_i[CTRL_PRE_BIT];
      if (wr_slave) begin
        mode_o <= smode_e'(wdata_i[SLV_MODE_LSB +: 3]);
        tsel_o <= wdata_i[SLV_TSEL_LSB +: TSEL_W];
      end
      if (wr_preset) shadow_o <= wdata_i[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tsc_core.sv
module tsc_core
  import tsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic             enc_dir_i,
  input  logic             enc_step_i,
  input  smode_e           mode_i,
  input  logic             pre_en_i,
  input  logic [CNT_W-1:0] shadow_i,
  input  logic             trig_lvl_i,
  input  logic             trig_rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] preset_eff_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] act_q;
  logic dir_eff, step, reload, wrap;

  assign dir_eff      = is_enc(mode_i) ? enc_dir_i : dir_i;
  assign preset_eff_o = pre_en_i ? act_q : shadow_i;

  always_comb begin
    unique case (mode_i)
      SM_INTCLK, SM_RELOAD, SM_START: step = en_i;
      SM_ENC_A, SM_ENC_B, SM_ENC_AB:  step = en_i & enc_step_i;
      SM_GATE:                        step = en_i & trig_lvl_i;
      SM_EXTCLK:                      step = en_i & trig_rise_i;
      default:                        step = 1'b0;
    endcase
  end

  assign reload = (mode_i == SM_RELOAD) && trig_rise_i;
  // up wraps at or above preset so a lowered preset cannot strand the count
  assign wrap   = step && !reload &&
                  (dir_eff ? (cnt_o == '0) : (cnt_o >= preset_eff_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      act_q <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= wrap;
      if (reload)          cnt_o <= preset_eff_o;
      else if (wrap)       cnt_o <= dir_eff ? shadow_i : '0;
      else if (step)       cnt_o <= dir_eff ? cnt_o - 1'b1 : cnt_o + 1'b1;
      if (!pre_en_i || wrap) act_q <= shadow_i;
    end
  end
endmodule

// File: rtl/trig_slave_counter.sv
module trig_slave_counter
  import tsc_pkg::*;
#(
  parameter int N_TRIG = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              enc_step_i,
  input  logic              enc_dir_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              upd_o
);
  localparam int TSEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1;

  logic [N_TRIG-1:0] lvl, rise;
  logic              en_q, dir_q, pre_en_q;
  smode_e            mode_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [CNT_W-1:0]  shadow_q, cnt, preset_eff;
  logic              trig_lvl, trig_rise, start_set;

  tsc_trig_sync #(.N_TRIG(N_TRIG)) u_sync (
    .clk_i, .rst_ni, .trig_i, .lvl_o(lvl), .rise_o(rise)
  );

  always_comb begin
    trig_lvl  = 1'b0;
    trig_rise = 1'b0;
    if (int'(tsel_q) < N_TRIG) begin
      trig_lvl  = lvl[tsel_q];
      trig_rise = rise[tsel_q];
    end
  end

  assign start_set = (mode_q == SM_START) && trig_rise;

  tsc_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .TSEL_W(TSEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .start_set_i(start_set), .enc_dir_i,
    .en_o(en_q), .dir_o(dir_q), .pre_en_o(pre_en_q),
    .mode_o(mode_q), .tsel_o(tsel_q), .shadow_o(shadow_q)
  );

  tsc_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .en_i(en_q), .dir_i(dir_q), .enc_dir_i, .enc_step_i,
    .mode_i(mode_q), .pre_en_i(pre_en_q), .shadow_i(shadow_q),
    .trig_lvl_i(trig_lvl), .trig_rise_i(trig_rise),
    .cnt_o(cnt), .preset_eff_o(preset_eff), .upd_o
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[CTRL_EN_BIT]  = en_q;
        rdata_o[CTRL_DIR_BIT] = dir_q;
        rdata_o[CTRL_PRE_BIT] = pre_en_q;
      end
      OFS_SLAVE: begin
        rdata_o[SLV_MODE_LSB +: 3]      = mode_q;
        rdata_o[SLV_TSEL_LSB +: TSEL_W] = tsel_q;
      end
      OFS_COUNT:  rdata_o[CNT_W-1:0] = cnt;
      OFS_PRESET: rdata_o[CNT_W-1:0] = shadow_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode,
  input logic             en,
  input logic             dir,
  input logic             enc_dir,
  input logic             trig_lvl,
  input logic             trig_rise,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preset_eff,
  input logic             upd,
  input logic             wr_en
);
  // R2
  int_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode == 3'd0 && en && !dir) && !upd) |-> cnt == $past(cnt) + 1'b1);

  // R3
  upd_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !$past(wr_en)) |-> (cnt == '0 || cnt == preset_eff));

  // R6
  enc_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode inside {3'd1, 3'd2, 3'd3}) |-> dir == $past(enc_dir));

  // R8
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode == 3'd5 && !trig_lvl) |-> $stable(cnt));

  // R10
  extclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode == 3'd7 && !trig_rise) |-> $stable(cnt));
endmodule

bind trig_slave_counter tsc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode(mode_q), .en(en_q), .dir(dir_q),
  .enc_dir(enc_dir_i), .trig_lvl(trig_lvl), .trig_rise(trig_rise),
  .cnt(cnt), .preset_eff(preset_eff), .upd(upd_o), .wr_en(wr_en_i)
);

// File: tb/trig_slave_counter_bench.sv
`timescale 1ns/1ps
module trig_slave_counter_bench;
  localparam int N_TRIG = 4;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam logic [7:0] A_CTRL = 8'h00, A_SLAVE = 8'h08, A_CNT = 8'h24, A_PRE = 8'h2C;

  // {preset, dir, steps, exp_cnt, exp_upd}
  typedef struct packed {
    logic [15:0] preset;
    logic        dir;
    logic [15:0] steps;
    logic [15:0] exp_cnt;
    logic [15:0] exp_upd;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd3, 1'b0, 16'd10, 16'd2, 16'd2},
    '{16'd3, 1'b1, 16'd10, 16'd2, 16'd3},
    '{16'd0, 1'b0, 16'd5,  16'd0, 16'd5},
    '{16'd7, 1'b0, 16'd7,  16'd7, 16'd0},
    '{16'd7, 1'b1, 16'd1,  16'd7, 16'd1},
    '{16'd5, 1'b1, 16'd6,  16'd0, 16'd1},
    '{16'd9, 1'b0, 16'd25, 16'd5, 16'd2}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_TRIG-1:0] trig = '0;
  logic enc_step = 1'b0, enc_dir = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic upd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trig_slave_counter #(.N_TRIG(N_TRIG), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_trig_slave_counter (
    .clk_i(clk), .rst_ni, .trig_i(trig), .enc_step_i(enc_step), .enc_dir_i(enc_dir),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .upd_o(upd)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; trig = '0; enc_step = 1'b0; enc_dir = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic steps(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int us;
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd(A_CNT, v);   chk("R1 count", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_SLAVE, v); chk("R1 slave", v, 0);
    rd(A_PRE, v);   chk("R1 preset", v, 0);
    chk("R1 upd", upd, 0);

    // vector table: mode 0, R3 up wrap and R4 down wrap
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(A_PRE, VECS[i].preset);
      wr(A_CTRL, 32'h1 | (VECS[i].dir << 4));
      us = 0;
      for (int k = 0; k < int'(VECS[i].steps); k++) begin
        @(negedge clk);
        us += upd;
      end
      rd(A_CNT, v);
      chk(VECS[i].dir ? "R4 vec count" : "R3 vec count", v, VECS[i].exp_cnt);
      chk(VECS[i].dir ? "R4 vec upd" : "R3 vec upd", us, VECS[i].exp_upd);
    end

    // R2 enable clear holds the count
    do_reset();
    wr(A_PRE, 100); wr(A_CTRL, 1);
    steps(5);
    wr(A_CTRL, 0);
    steps(4);
    rd(A_CNT, v); chk("R2 hold", v, 6);

    // R3 pulse lands with the wrapped value
    do_reset();
    wr(A_PRE, 2); wr(A_CTRL, 1);
    steps(2); chk("R3 no early upd", upd, 0);
    steps(1); chk("R3 upd pulse", upd, 1);
    rd(A_CNT, v); chk("R3 wrap value", v, 0);
    steps(1); chk("R3 upd single", upd, 0);

    // R5 preload deferred
    do_reset();
    wr(A_PRE, 3); wr(A_CTRL, 32'h80); wr(A_PRE, 1); wr(A_CTRL, 32'h81);
    steps(2); rd(A_CNT, v); chk("R5 old preset active", v, 2);
    rd(A_PRE, v); chk("R5 preset readback", v, 1);
    steps(2); chk("R5 wrap on old", upd, 1);
    steps(1); rd(A_CNT, v); chk("R5 new after wrap", v, 1);
    steps(1); chk("R5 wrap on new", upd, 1);
    // R5 immediate
    do_reset();
    wr(A_PRE, 3); wr(A_CTRL, 1);
    steps(1);
    wr(A_PRE, 1);
    rd(A_CNT, v); chk("R5 immediate step", v, 2);
    steps(1); chk("R5 immediate wrap", upd, 1);
    rd(A_CNT, v); chk("R5 immediate value", v, 0);

    // R6 encoder modes
    do_reset();
    wr(A_PRE, 100); wr(A_SLAVE, 1); wr(A_CTRL, 1);
    enc_dir = 1'b0; enc_step = 1'b1;
    steps(3); enc_step = 1'b0;
    rd(A_CNT, v); chk("R6 enc up", v, 3);
    enc_dir = 1'b1; enc_step = 1'b1;
    steps(1); enc_step = 1'b0;
    rd(A_CNT, v); chk("R6 enc down", v, 2);
    wr(A_CTRL, 32'h01);
    rd(A_CTRL, v); chk("R6 dir read-only", v & 32'h10, 32'h10);
    steps(3); rd(A_CNT, v); chk("R6 no step hold", v, 2);
    wr(A_SLAVE, 3); enc_dir = 1'b0; enc_step = 1'b1;
    steps(1); enc_step = 1'b0;
    rd(A_CNT, v); chk("R6 mode3 step", v, 3);

    // R7 reload mode
    do_reset();
    wr(A_PRE, 50); wr(A_SLAVE, 4); wr(A_CTRL, 32'h11);
    steps(20); rd(A_CNT, v); chk("R4 down run", v, 31);
    trig[0] = 1'b1;
    steps(2); rd(A_CNT, v); chk("R7 before reload", v, 29);
    steps(1); rd(A_CNT, v); chk("R7 reload", v, 50);
    steps(3); rd(A_CNT, v); chk("R7 single reload", v, 47);
    trig[0] = 1'b0;

    // R8 gated mode
    do_reset();
    wr(A_PRE, 200); wr(A_SLAVE, 5); wr(A_CTRL, 1);
    steps(5); rd(A_CNT, v); chk("R8 gate low", v, 0);
    trig[0] = 1'b1; steps(6);
    rd(A_CNT, v); chk("R8 gate high", v, 4);
    trig[0] = 1'b0; steps(5);
    rd(A_CNT, v); chk("R8 hold after fall", v, 6);

    // R9 start mode
    do_reset();
    wr(A_PRE, 200); wr(A_SLAVE, 6);
    steps(4); rd(A_CNT, v); chk("R9 idle", v, 0);
    trig[0] = 1'b1; steps(3);
    rd(A_CTRL, v); chk("R9 enable set", v & 1, 1);
    rd(A_CNT, v); chk("R9 not yet", v, 0);
    steps(2); rd(A_CNT, v); chk("R9 counting", v, 2);
    wr(A_CTRL, 0);
    trig[0] = 1'b0; steps(4);
    rd(A_CNT, v); chk("R9 stopped", v, 3);
    trig[0] = 1'b1; steps(5);
    rd(A_CNT, v); chk("R9 not cleared", v, 5);
    trig[0] = 1'b0;

    // R10 trigger edges clock the count
    do_reset();
    wr(A_PRE, 200); wr(A_SLAVE, 7); wr(A_CTRL, 1);
    for (int p = 0; p < 3; p++) begin
      trig[0] = 1'b1; steps(3); trig[0] = 1'b0; steps(3);
    end
    steps(3); rd(A_CNT, v); chk("R10 three edges", v, 3);
    trig[0] = 1'b1; steps(10);
    rd(A_CNT, v); chk("R10 held high once", v, 4);
    trig[0] = 1'b0; steps(4);

    // R11 trigger select
    do_reset();
    wr(A_PRE, 200); wr(A_SLAVE, 32'h27); wr(A_CTRL, 1);
    trig = 4'b1011; steps(4); trig = '0; steps(4);
    rd(A_CNT, v); chk("R11 other lines ignored", v, 0);
    trig = 4'b0100; steps(4); trig = '0; steps(4);
    rd(A_CNT, v); chk("R11 selected line", v, 1);
    rd(A_SLAVE, v); chk("R11 slave readback", v, 32'h27);

    // R12 register map
    do_reset();
    wr(A_PRE, 32'h1234);
    rd(A_PRE, v); chk("R12 preset offset", v, 32'h1234);
    wr(A_CTRL, 32'hFF);
    rd(A_CTRL, v); chk("R12 ctrl bits", v, 32'h91);
    rd(8'h10, v); chk("R12 unmapped", v, 0);

    // R1 reset mid-run
    do_reset();
    rd(A_CNT, v); chk("R1 count after reset", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl after reset", v, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule